// File: doc/BRIEF.md
# Quad DAC Serial Register Interface

This block is the digital front end of a four-channel, 16-bit current-output converter. A host shifts an 18-bit frame into a shift register on the rising edges of a serial clock while chip select is held low. The frame carries a 2-bit channel address followed by 16 data bits, most significant bit first. When chip select returns high, the data bits are written into the input register of the addressed channel.

A second rank of registers, the DAC registers, drives the converter. An active-low load strobe controls this rank. It is level sensitive: while the strobe is low, all four DAC registers follow their input registers, with no clock involved. An active-low asynchronous reset loads both ranks with zero or with midscale (only bit 15 set), as chosen by a strap input. The bit leaving the shift register is re-registered on the falling clock edge and driven out on a serial output, so several devices can be chained.

Top module: `qdac_serial_if`

## Requirements
- R1: On each rising edge of `sclk_i` with `cs_ni` low, `sdi_i` is shifted into an 18-bit register, first bit most significant. When `cs_ni` rises, bits 17:16 of that register select the channel (0=A, 1=B, 2=C, 3=D). Bits 15:0 are written to that channel's input register, and the other channels' input registers keep their values.
- R2: While `cs_ni` is high, rising edges of `sclk_i` leave the shift register unchanged, and `sdo_o` therefore holds its value.
- R3: A frame with fewer or more than 18 clocks is still committed when `cs_ni` rises, using the last 18 bits shifted. After reset the shift register holds zeros.
- R4: While `ldac_ni` is low, every DAC register equals its input register. This includes an input register written by a chip-select rise during the low phase, and it needs no further clock edge.
- R5: While `ldac_ni` is high, the DAC registers hold their values, whatever serial frames are committed.
- R6: While `rst_ni` is low with `mid_sel_i` at 0, all input and DAC registers read 0x0000, and the shift register and `sdo_o` are cleared.
- R7: While `rst_ni` is low with `mid_sel_i` at 1, all input and DAC registers read 0x8000.
- R8: Reset takes priority: a low `ldac_ni` or a frame committed during reset does not change the reset values.
- R9: A bit sampled from `sdi_i` on rising edge k appears on `sdo_o` after the falling edge that follows rising edge k+17, so a downstream device samples it on rising edge k+18, the 19th clock pulse.
- R10: The four DAC register values are presented on `dac_o`, with channel n at bits [16n+15:16n].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk_i | input | 1 | Serial clock. Shifts on the rising edge; the serial output updates on the falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mid_sel_i | input | 1 | Reset strap: 0 gives zero scale, 1 gives midscale |
| cs_ni | input | 1 | Chip select, active low. Its rising edge commits the frame |
| sdi_i | input | 1 | Serial data in |
| ldac_ni | input | 1 | Load strobe, active low and level sensitive |
| sdo_o | output | 1 | Serial data out for daisy chaining |
| dac_o | output | 64 | DAC register values, channel A in the low 16 bits |

## Verification
The bench builds the block with its default parameters: four channels and 16 data bits, which gives an 18-bit frame. With these values every 2-bit address reaches a real channel, and the midscale reset value is bit 15. The 19-pulse serial latency can be checked exactly, by following a single marker bit through a cleared shift register. A reference model replays the serial stream from a bit queue. Each time chip select rises it rebuilds the committed word from the last 18 queued bits, so short and long frames need no special handling.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int unsigned QDAC_NUM_CH = 4;
  localparam int unsigned QDAC_DATA_W = 16;
endpackage

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
  parameter int unsigned FRAME_W = 18
) (
  input  logic               sclk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sdi_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               sdo_o
);
  logic [FRAME_W-1:0] shreg_q;

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni)     shreg_q <= '0;
    else if (!cs_ni) shreg_q <= {shreg_q[FRAME_W-2:0], sdi_i};
  end

  // falling-edge retime adds the extra pulse of chain latency
  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) sdo_o <= 1'b0;
    else         sdo_o <= shreg_q[FRAME_W-1];
  end

  assign frame_o = shreg_q;
endmodule

// File: rtl/qdac_input_bank.sv
module qdac_input_bank #(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned DATA_W  = 16,
  localparam int unsigned ADDR_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned FRAME_W = ADDR_W + DATA_W
) (
  input  logic                     cs_ni,
  input  logic                     rst_ni,
  input  logic                     mid_sel_i,
  input  logic [FRAME_W-1:0]       frame_i,
  output logic [NUM_CH*DATA_W-1:0] in_o
);
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic [DATA_W-1:0] rst_val;

  assign addr    = frame_i[FRAME_W-1 -: ADDR_W];
  assign data    = frame_i[DATA_W-1:0];
  assign rst_val = {mid_sel_i, {(DATA_W-1){1'b0}}};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge cs_ni or negedge rst_ni) begin
      if (!rst_ni)                          in_o[g*DATA_W +: DATA_W] <= rst_val;
      else if (addr == ADDR_W'(g))          in_o[g*DATA_W +: DATA_W] <= data;
    end
  end
endmodule

// File: rtl/qdac_load_latch.sv
module qdac_load_latch #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic                     rst_ni,
  input  logic                     ldac_ni,
  input  logic                     mid_sel_i,
  input  logic [NUM_CH*DATA_W-1:0] in_i,
  output logic [NUM_CH*DATA_W-1:0] dac_o
);
  logic [DATA_W-1:0] rst_val;
  assign rst_val = {mid_sel_i, {(DATA_W-1){1'b0}}};

  // transparent while strobe low; reset wins
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_latch begin
      if (!rst_ni)       dac_o[g*DATA_W +: DATA_W] = rst_val;
      else if (!ldac_ni) dac_o[g*DATA_W +: DATA_W] = in_i[g*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/qdac_serial_if.sv
module qdac_serial_if
  import qdac_pkg::*;
#(
  parameter int unsigned NUM_CH = QDAC_NUM_CH,
  parameter int unsigned DATA_W = QDAC_DATA_W,
  localparam int unsigned ADDR_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned FRAME_W = ADDR_W + DATA_W
) (
  input  logic                     sclk_i,
  input  logic                     rst_ni,
  input  logic                     mid_sel_i,
  input  logic                     cs_ni,
  input  logic                     sdi_i,
  input  logic                     ldac_ni,
  output logic                     sdo_o,
  output logic [NUM_CH*DATA_W-1:0] dac_o
);
  logic [FRAME_W-1:0]       frame_q;
  logic [NUM_CH*DATA_W-1:0] in_q;

  qdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .sclk_i (sclk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .sdi_i  (sdi_i),
    .frame_o(frame_q),
    .sdo_o  (sdo_o)
  );

  qdac_input_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_in (
    .cs_ni    (cs_ni),
    .rst_ni   (rst_ni),
    .mid_sel_i(mid_sel_i),
    .frame_i  (frame_q),
    .in_o     (in_q)
  );

  qdac_load_latch #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dac (
    .rst_ni   (rst_ni),
    .ldac_ni  (ldac_ni),
    .mid_sel_i(mid_sel_i),
    .in_i     (in_q),
    .dac_o    (dac_o)
  );
endmodule

// File: rtl/qdac_serial_if_chk.sv
module qdac_serial_if_chk #(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned FRAME_W = 18
) (
  input logic                     sclk_i,
  input logic                     rst_ni,
  input logic                     mid_sel_i,
  input logic                     cs_ni,
  input logic                     ldac_ni,
  input logic                     sdo_o,
  input logic [NUM_CH*DATA_W-1:0] dac_o,
  input logic [FRAME_W-1:0]       frame_i,
  input logic [NUM_CH*DATA_W-1:0] in_i
);
  // R2
  shift_hold_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(frame_i));

  // R9
  sdo_tap_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    sdo_o == frame_i[FRAME_W-1]);

  // R1
  in_hold_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (!cs_ni && !$past(cs_ni)) |-> $stable(in_i));

  // R4
  load_follow_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !ldac_ni |-> dac_o == in_i);

  // R6 R7
  reset_val_chk: assert property (@(posedge sclk_i)
    !rst_ni |-> dac_o == {NUM_CH{mid_sel_i, {(DATA_W-1){1'b0}}}});
endmodule

bind qdac_serial_if qdac_serial_if_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .FRAME_W(FRAME_W)
) u_chk (
  .sclk_i   (sclk_i),
  .rst_ni   (rst_ni),
  .mid_sel_i(mid_sel_i),
  .cs_ni    (cs_ni),
  .ldac_ni  (ldac_ni),
  .sdo_o    (sdo_o),
  .dac_o    (dac_o),
  .frame_i  (frame_q),
  .in_i     (in_q)
);

// File: tb/qdac_serial_if_tb.sv
module qdac_serial_if_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DW  = 16;
  localparam int FW  = 18;

  logic sclk = 1'b0;
  logic rst_n = 1'b1;
  logic mid_sel = 1'b0;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;
  logic ldac_n = 1'b1;
  logic sdo;
  logic [NCH*DW-1:0] dac;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R6";

  qdac_serial_if u_dut (
    .sclk_i(sclk), .rst_ni(rst_n), .mid_sel_i(mid_sel), .cs_ni(cs_n),
    .sdi_i(sdi), .ldac_ni(ldac_n), .sdo_o(sdo), .dac_o(dac)
  );

  always #(CLK_PERIOD/2) sclk = ~sclk;

  // reference model
  bit          hist[$];
  logic        exp_sdo = 1'b0;
  logic [15:0] in_mdl [NCH];
  logic [15:0] dac_mdl[NCH];

  function automatic logic [15:0] rst_word();
    return mid_sel ? 16'h8000 : 16'h0000;
  endfunction

  always @(posedge sclk) if (rst_n && !cs_n) begin
    hist.push_back(sdi);
    if (hist.size() > 64) void'(hist.pop_front());
  end

  always @(negedge sclk) begin
    if (!rst_n) exp_sdo = 1'b0;
    else if (hist.size() >= FW) exp_sdo = hist[hist.size()-FW];
    else exp_sdo = 1'b0;
  end

  always @(negedge rst_n) begin
    hist.delete();
    exp_sdo = 1'b0;
  end

  always @(posedge cs_n) if (rst_n) begin
    logic [FW-1:0] w;
    w = '0;
    for (int k = 0; k < FW; k++)
      if (hist.size() > k) w[k] = hist[hist.size()-1-k];
    in_mdl[w[17:16]] = w[15:0];
  end

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // per-cycle comparison
  always @(negedge sclk) begin
    #(CLK_PERIOD/4);
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        in_mdl[c] = rst_word();
        dac_mdl[c] = rst_word();
      end
    end else if (!ldac_n) begin
      for (int c = 0; c < NCH; c++) dac_mdl[c] = in_mdl[c];
    end
    chk("R9", "sdo", 32'(sdo), 32'(exp_sdo));
    for (int c = 0; c < NCH; c++)
      chk(cur_req, $sformatf("dac[%0d]", c), 32'(dac[c*DW +: DW]), 32'(dac_mdl[c]));
  end

  task automatic send_bits(logic [31:0] word, int nbits);
    for (int i = nbits-1; i >= 0; i--) begin
      @(posedge sclk); #1;
      cs_n = 1'b0;
      sdi = word[i];
    end
    @(posedge sclk); #1;
    cs_n = 1'b1;
    sdi = 1'b0;
  endtask

  task automatic write_ch(int ch, logic [15:0] val);
    send_bits({14'b0, 2'(ch), val}, FW);
  endtask

  task automatic do_reset(logic strap);
    @(posedge sclk); #1;
    mid_sel = strap;
    rst_n = 1'b0;
    repeat (3) @(posedge sclk);
    #1 rst_n = 1'b1;
  endtask

  task automatic pulse_load();
    @(posedge sclk); #1 ldac_n = 1'b0;
    repeat (2) @(posedge sclk);
    #1 ldac_n = 1'b1;
  endtask

  task automatic chk_dac(string req, int ch, logic [15:0] exp);
    @(negedge sclk); #(CLK_PERIOD/4 + 1);
    chk(req, $sformatf("dac ch%0d", ch), 32'(dac[ch*DW +: DW]), 32'(exp));
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge sclk);
    #1 rst_n = 1'b1;
    // R6 zero-scale reset
    for (int c = 0; c < NCH; c++) chk_dac("R6", c, 16'h0000);

    // R1 R5 writes, strobe idle
    cur_req = "R5";
    write_ch(0, 16'h1234);
    write_ch(1, 16'hABCD);
    write_ch(2, 16'h5A5A);
    write_ch(3, 16'hFFFF);
    for (int c = 0; c < NCH; c++) chk_dac("R5", c, 16'h0000);

    // R4 R10 load all channels together
    cur_req = "R4";
    pulse_load();
    chk_dac("R1", 0, 16'h1234);
    chk_dac("R1", 1, 16'hABCD);
    chk_dac("R10", 2, 16'h5A5A);
    chk_dac("R10", 3, 16'hFFFF);

    // R2 clocks with chip select high
    cur_req = "R2";
    for (int i = 0; i < 20; i++) begin
      @(posedge sclk); #1 sdi = i[0];
    end
    pulse_load();
    chk_dac("R2", 3, 16'hFFFF);

    // R3 short frame: 8 old ones + 10 zeros -> ch D, 0xFC00
    cur_req = "R3";
    send_bits(32'h0, 10);
    pulse_load();
    chk_dac("R3", 3, 16'hFC00);
    // R3 long frame: extra leading bits dropped -> ch B 0x0F0F
    send_bits({10'b0, 4'hF, 2'b01, 16'h0F0F}, 22);
    pulse_load();
    chk_dac("R3", 1, 16'h0F0F);

    // R4 strobe held low, commit follows without another edge
    cur_req = "R4";
    @(posedge sclk); #1 ldac_n = 1'b0;
    write_ch(2, 16'h0123);
    chk_dac("R4", 2, 16'h0123);
    #1 ldac_n = 1'b1;
    @(posedge sclk);

    // R7 midscale reset
    cur_req = "R7";
    do_reset(1'b1);
    for (int c = 0; c < NCH; c++) chk_dac("R7", c, 16'h8000);

    // R8 reset wins over strobe and commit
    cur_req = "R8";
    @(posedge sclk); #1 rst_n = 1'b0; ldac_n = 1'b0;
    write_ch(1, 16'h7777);
    chk_dac("R8", 1, 16'h8000);
    @(posedge sclk); #1 rst_n = 1'b1;
    chk_dac("R8", 1, 16'h8000);
    @(posedge sclk); #1 ldac_n = 1'b1;

    // R6 again then R9 latency with one marker bit
    cur_req = "R6";
    do_reset(1'b0);
    chk_dac("R6", 1, 16'h0000);
    cur_req = "R9";
    @(posedge sclk); #1 cs_n = 1'b0; sdi = 1'b1;
    for (int n = 1; n <= 24; n++) begin
      @(posedge sclk); #1 sdi = 1'b0;
      @(negedge sclk); #(CLK_PERIOD/4 + 1);
      chk("R9", $sformatf("sdo after edge %0d", n), 32'(sdo), 32'(n == 18));
    end
    @(posedge sclk); #1 cs_n = 1'b1;
    repeat (4) @(posedge sclk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule